// File: doc/BRIEF.md
# Three-Wire Serial Memory Host Controller

This block is the master side of a three-wire link to a small serial nonvolatile memory. The link has a serial clock, a chip-enable line and one bidirectional data line. A command arrives on a valid/ready request port. It carries a 2-bit opcode, a 7-bit word address and an 8-bit data value. The controller builds the serial frame for that command and shifts it out with chip enable held high. It then drops chip enable to launch the operation.

A reprogram command is finished by a clock pulse, with the data line choosing erase (1) or write (0). After that pulse the controller stays busy for a programmable settling time. A read command releases the data line and pulses the clock eight times. It samples one returned bit after each trailing edge, and reports the byte with a one-cycle done strobe.

The serial clock is divided down from the system clock. The same parameter sets the high half and the low half of each serial clock period.

Top module: `ser3_host`

## Requirements
- R1: While reset is asserted and right after it, chip enable is high, the serial clock is low, the data line is not driven, ready is high and done is low.
- R2: Opcode 00 (read) sends an 8-bit frame. Bits 0..6 are the address, least significant bit first, and bit 7 is a 0 control bit.
- R3: Opcode 01 (erase) sends an 8-bit frame. Bits 0..6 are the address, least significant bit first, and bit 7 is a 1 control bit.
- R4: Opcodes 10 (write) and 11 (erase-and-write) send a 16-bit frame, least significant bit first: 8 data bits, then 7 address bits, then a 1 control bit.
- R5: Chip enable stays high while frame bits are clocked. It falls after the last frame bit with the serial clock low. The driven data line changes only while the serial clock is low.
- R6: After chip enable falls for a reprogram, the controller drives the data line and gives one clock pulse: 1 for erase, 0 for write. Erase-and-write gives an erase pulse, waits, then gives a write pulse, with chip enable low throughout.
- R7: For a read, the data line is released when chip enable falls and stays released until chip enable rises. Eight clock pulses follow. A bit is sampled after each trailing edge, and the first bit is the least significant. When the byte is complete, chip enable rises and a single-cycle done strobe presents the byte.
- R8: After each reprogram pulse, ready stays low for at least PROG_WAIT system clock cycles.
- R9: Ready is low from the accepted request until the operation ends, and a request presented while ready is low has no effect.
- R10: Each serial clock high phase lasts exactly DIV_HALF system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Command request valid |
| req_ready_o | output | 1 | Controller idle, request is taken |
| req_cmd_i | input | 2 | Opcode: 00 read, 01 erase, 10 write, 11 erase-and-write |
| req_addr_i | input | 7 | Word address |
| req_data_i | input | 8 | Data for write commands |
| rd_done_o | output | 1 | One-cycle strobe when a read byte is ready |
| rd_data_o | output | 8 | Byte returned by the last read |
| sclk_o | output | 1 | Serial clock to the memory |
| ce_o | output | 1 | Chip enable line: high while loading, low to run |
| sd_o | output | 1 | Serial data driven to the memory |
| sd_oe_o | output | 1 | Output enable for the data line driver |
| sd_i | input | 1 | Serial data returned by the memory |

## Verification
The assertions watch several rules on every cycle:
- chip enable falls only with the serial clock low;
- driven data never moves on a rising serial clock edge;
- the released data line stays released until chip enable rises;
- ready stays low while chip enable is low;
- the done strobe is one cycle long and comes only when the controller is idle;
- the settling time after each reprogram pulse is held, using a counter in the checker.

Other behaviour can only be shown by the bench's scenarios, run against a behavioural memory model. These are the frame bit order and length for each opcode, the level on the data line at each programming pulse, and the bytes read back after a mix of writes, erases and erase-and-writes. The scenarios also show that a request presented while the controller is busy is dropped.

// File: rtl/ser3_pkg.sv
package ser3_pkg;
  typedef enum logic [1:0] {
    CMD_READ  = 2'b00,
    CMD_ERASE = 2'b01,
    CMD_WRITE = 2'b10,
    CMD_ERWR  = 2'b11
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SH_LO,
    ST_SH_HI,
    ST_CE_LO,
    ST_P_HI,
    ST_P_WAIT,
    ST_R_HI,
    ST_R_LO
  } state_e;

  localparam int FRAME_W = 16;
  localparam int LEN_W   = 5;
endpackage

// File: rtl/ser3_clkdiv.sv
module ser3_clkdiv #(
  parameter int DIV_HALF = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int CW = $clog2(DIV_HALF + 1);
  logic [CW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == CW'(DIV_HALF - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!en_i || tick_o) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ser3_wait.sv
module ser3_wait #(
  parameter int PROG_WAIT = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic done_o
);
  localparam int WW = $clog2(PROG_WAIT + 1) < 1 ? 1 : $clog2(PROG_WAIT + 1);
  logic [WW-1:0] cnt_q;

  assign done_o = (cnt_q == '0) && !load_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (load_i)      cnt_q <= WW'(PROG_WAIT);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/ser3_framer.sv
module ser3_framer
  import ser3_pkg::*;
(
  input  cmd_e               cmd_i,
  input  logic [6:0]         addr_i,
  input  logic [7:0]         data_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic [LEN_W-1:0]   len_o
);
  always_comb begin
    unique case (cmd_i)
      CMD_READ: begin
        frame_o = {8'h00, 1'b0, addr_i};
        len_o   = LEN_W'(8);
      end
      CMD_ERASE: begin
        frame_o = {8'h00, 1'b1, addr_i};
        len_o   = LEN_W'(8);
      end
      default: begin
        frame_o = {1'b1, addr_i, data_i};
        len_o   = LEN_W'(16);
      end
    endcase
  end
endmodule

// File: rtl/ser3_host.sv
module ser3_host
  import ser3_pkg::*;
#(
  parameter int DIV_HALF  = 4,
  parameter int PROG_WAIT = 1000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_valid_i,
  output logic       req_ready_o,
  input  logic [1:0] req_cmd_i,
  input  logic [6:0] req_addr_i,
  input  logic [7:0] req_data_i,
  output logic       rd_done_o,
  output logic [7:0] rd_data_o,
  output logic       sclk_o,
  output logic       ce_o,
  output logic       sd_o,
  output logic       sd_oe_o,
  input  logic       sd_i
);
  state_e             state_q;
  cmd_e               cmd_q;
  logic [FRAME_W-1:0] frame_q, frame_d;
  logic [LEN_W-1:0]   len_q, len_d;
  logic [LEN_W-1:0]   idx_q;
  logic [2:0]         rbit_q;
  logic [7:0]         rx_q, rd_data_q;
  logic               pass2_q, done_q, sclk_q, ce_q, sd_q, oe_q;
  logic               tick, div_en, wait_load, wait_done;

  ser3_framer u_framer (
    .cmd_i  (cmd_e'(req_cmd_i)),
    .addr_i (req_addr_i),
    .data_i (req_data_i),
    .frame_o(frame_d),
    .len_o  (len_d)
  );

  assign div_en = (state_q != ST_IDLE) && (state_q != ST_P_WAIT);

  ser3_clkdiv #(.DIV_HALF(DIV_HALF)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (div_en),
    .tick_o(tick)
  );

  assign wait_load = (state_q == ST_P_HI) && tick;

  ser3_wait #(.PROG_WAIT(PROG_WAIT)) u_wait (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(wait_load),
    .done_o(wait_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cmd_q     <= CMD_READ;
      frame_q   <= '0;
      len_q     <= '0;
      idx_q     <= '0;
      rbit_q    <= '0;
      rx_q      <= '0;
      rd_data_q <= '0;
      pass2_q   <= 1'b0;
      done_q    <= 1'b0;
      sclk_q    <= 1'b0;
      ce_q      <= 1'b1;
      sd_q      <= 1'b0;
      oe_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          cmd_q   <= cmd_e'(req_cmd_i);
          frame_q <= frame_d;
          len_q   <= len_d;
          idx_q   <= '0;
          sd_q    <= frame_d[0];
          oe_q    <= 1'b1;
          ce_q    <= 1'b1;
          state_q <= ST_SH_LO;
        end
        ST_SH_LO: if (tick) begin
          sclk_q  <= 1'b1;
          state_q <= ST_SH_HI;
        end
        ST_SH_HI: if (tick) begin
          sclk_q <= 1'b0;
          if (idx_q == len_q - 1'b1) begin
            // frame complete: launch the operation
            ce_q    <= 1'b0;
            pass2_q <= 1'b0;
            state_q <= ST_CE_LO;
            if (cmd_q == CMD_READ) oe_q <= 1'b0;
            else                   sd_q <= (cmd_q != CMD_WRITE);
          end else begin
            idx_q   <= idx_q + 1'b1;
            sd_q    <= frame_q[1];
            frame_q <= frame_q >> 1;
            state_q <= ST_SH_LO;
          end
        end
        ST_CE_LO: if (tick) begin
          sclk_q  <= 1'b1;
          rbit_q  <= '0;
          state_q <= (cmd_q == CMD_READ) ? ST_R_HI : ST_P_HI;
        end
        ST_P_HI: if (tick) begin
          sclk_q  <= 1'b0;
          state_q <= ST_P_WAIT;
        end
        ST_P_WAIT: if (wait_done) begin
          if (cmd_q == CMD_ERWR && !pass2_q) begin
            // second pass of erase-and-write: write pulse
            pass2_q <= 1'b1;
            sd_q    <= 1'b0;
            state_q <= ST_CE_LO;
          end else begin
            ce_q    <= 1'b1;
            oe_q    <= 1'b0;
            state_q <= ST_IDLE;
          end
        end
        ST_R_HI: if (tick) begin
          sclk_q  <= 1'b0;
          state_q <= ST_R_LO;
        end
        ST_R_LO: if (tick) begin
          rx_q <= {sd_i, rx_q[7:1]};
          if (rbit_q == 3'd7) begin
            rd_data_q <= {sd_i, rx_q[7:1]};
            done_q    <= 1'b1;
            ce_q      <= 1'b1;
            state_q   <= ST_IDLE;
          end else begin
            rbit_q  <= rbit_q + 1'b1;
            sclk_q  <= 1'b1;
            state_q <= ST_R_HI;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign rd_done_o   = done_q;
  assign rd_data_o   = rd_data_q;
  assign sclk_o      = sclk_q;
  assign ce_o        = ce_q;
  assign sd_o        = sd_q;
  assign sd_oe_o     = oe_q;
endmodule

// File: rtl/ser3_host_chk.sv
module ser3_host_chk #(
  parameter int PROG_WAIT = 1000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic req_ready_o,
  input logic rd_done_o,
  input logic sclk_o,
  input logic ce_o,
  input logic sd_o,
  input logic sd_oe_o
);
  logic ready_d, sclk_d, prog_seen;
  int   wait_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_d   <= 1'b1;
      sclk_d    <= 1'b0;
      prog_seen <= 1'b0;
      wait_cnt  <= 0;
    end else begin
      ready_d <= req_ready_o;
      sclk_d  <= sclk_o;
      if (sclk_d && !sclk_o && !ce_o && sd_oe_o) begin
        wait_cnt  <= 0;
        prog_seen <= 1'b1;
      end else begin
        if (wait_cnt < 32'h7fff_ffff) wait_cnt <= wait_cnt + 1;
        if (req_ready_o && !ready_d) prog_seen <= 1'b0;
      end
    end
  end

  AST_CE_FALL_SCLK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ce_o) |-> !sclk_o); // R5
  AST_SD_STABLE_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sclk_o) && sd_oe_o) |-> $stable(sd_o)); // R5
  AST_RELEASE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_o && !sd_oe_o) |=> (ce_o || !sd_oe_o)); // R7
  AST_DONE_IN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_done_o |-> (ce_o && req_ready_o)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_done_o |=> !rd_done_o); // R7
  AST_BUSY_CE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_o |-> !req_ready_o); // R9
  AST_PROG_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ready_o && !ready_d && prog_seen) |-> (wait_cnt >= PROG_WAIT)); // R8
endmodule

bind ser3_host ser3_host_chk #(.PROG_WAIT(PROG_WAIT)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_ready_o(req_ready_o),
  .rd_done_o  (rd_done_o),
  .sclk_o     (sclk_o),
  .ce_o       (ce_o),
  .sd_o       (sd_o),
  .sd_oe_o    (sd_oe_o)
);

// File: tb/tb_ser3_host.sv
module tb_ser3_host;
  localparam int DIV_HALF  = 3;
  localparam int PROG_WAIT = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic       req_valid = 1'b0, req_ready;
  logic [1:0] req_cmd = '0;
  logic [6:0] req_addr = '0;
  logic [7:0] req_data = '0;
  logic       rd_done, sclk_o, ce_o, sd_o, sd_oe_o;
  logic [7:0] rd_data;
  logic       sd_i = 1'b0;

  ser3_host #(.DIV_HALF(DIV_HALF), .PROG_WAIT(PROG_WAIT)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_cmd_i(req_cmd), .req_addr_i(req_addr), .req_data_i(req_data),
    .rd_done_o(rd_done), .rd_data_o(rd_data),
    .sclk_o(sclk_o), .ce_o(ce_o), .sd_o(sd_o), .sd_oe_o(sd_oe_o), .sd_i(sd_i)
  );

  int checks = 0, errors = 0;
  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // scoreboard queues
  int         exp_cmd_q[$];
  int         exp_len_q[$];
  logic [15:0] exp_frame_q[$];
  logic [7:0] exp_rd_q[$];
  bit         exp_pulse_q[$];
  logic [7:0] ref_mem[128];

  function automatic string frame_req(int c);
    if (c == 0) return "R2";
    if (c == 1) return "R3";
    return "R4";
  endfunction

  // behavioural memory model
  logic [15:0] sh = '0;
  int          nbits = 0, rpos = 0;
  bit          rd_mode = 0, rd_loaded = 0, conflict = 0;
  logic [6:0]  m_addr = '0;
  logic [7:0]  m_wdata = '0, rbyte = '0;
  logic [7:0]  mdl_mem[128];

  always @(posedge sclk_o) begin
    if (ce_o) begin
      if (nbits < 16) sh[nbits] = sd_o;
      nbits++;
    end else if (rd_mode) begin
      if (!rd_loaded) begin
        rbyte = mdl_mem[m_addr];
        rd_loaded = 1;
      end
    end else begin
      if (exp_pulse_q.size() == 0) chk(0, "R6", "unexpected pulse", sd_o, 0);
      else begin
        bit e;
        e = exp_pulse_q.pop_front();
        chk(sd_o == e, "R6", "pulse level", sd_o, e);
      end
      if (sd_o) mdl_mem[m_addr] = 8'h00;
      else      mdl_mem[m_addr] = m_wdata;
    end
  end

  always @(negedge ce_o) begin
    logic [15:0] got;
    got = (nbits == 8) ? {8'h00, sh[7:0]} : sh;
    chk(!sclk_o, "R5", "ce fall with sclk low", sclk_o, 0);
    if (exp_frame_q.size() == 0) chk(0, "R9", "unrequested frame", nbits, 0);
    else begin
      int c, l;
      logic [15:0] f;
      c = exp_cmd_q.pop_front();
      l = exp_len_q.pop_front();
      f = exp_frame_q.pop_front();
      chk(nbits == l, frame_req(c), "frame length", nbits, l);
      chk(got == f, frame_req(c), "frame bits", got, f);
    end
    if (nbits == 16) begin
      m_wdata = sh[7:0];
      m_addr  = sh[14:8];
      rd_mode = !sh[15];
    end else begin
      m_addr  = sh[6:0];
      rd_mode = !sh[7];
    end
    rd_loaded = 0;
    rpos = 0;
    conflict = 0;
  end

  always @(negedge sclk_o) begin
    if (!ce_o && rd_mode && rd_loaded && rpos < 8) begin
      sd_i = rbyte[rpos];
      rpos++;
    end
  end

  always @(posedge ce_o) begin
    if (rd_mode) begin
      chk(!conflict, "R7", "line released during read", conflict, 0);
      chk(rpos == 8, "R7", "read clock count", rpos, 8);
    end
    nbits = 0;
    rd_mode = 0;
    sd_i = 1'b0;
  end

  // cycle monitor
  logic sclk_prev = 0, sd_prev = 0, ready_prev = 1, done_prev = 0;
  int   hi_cnt = 0, wait_cnt = 0;
  bit   prog_flag = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (sclk_o && !sclk_prev && sd_oe_o)
        chk(sd_o == sd_prev, "R5", "data moved at sclk rise", sd_o, sd_prev);
      if (sclk_o) hi_cnt++;
      else begin
        if (sclk_prev) chk(hi_cnt == DIV_HALF, "R10", "sclk high time", hi_cnt, DIV_HALF);
        hi_cnt = 0;
      end
      if (!ce_o && rd_mode && sd_oe_o) conflict = 1;
      if (!sclk_o && sclk_prev && !ce_o && sd_oe_o) begin
        wait_cnt = 0;
        prog_flag = 1;
      end else wait_cnt++;
      if (req_ready && !ready_prev && prog_flag) begin
        chk(wait_cnt >= PROG_WAIT, "R8", "settle time", wait_cnt, PROG_WAIT);
        prog_flag = 0;
      end
      if (rd_done) begin
        chk(!done_prev, "R7", "done single cycle", done_prev, 0);
        if (exp_rd_q.size() == 0) chk(0, "R7", "unexpected done", rd_data, 0);
        else begin
          logic [7:0] e;
          e = exp_rd_q.pop_front();
          chk(rd_data == e, "R7", "read byte", rd_data, e);
        end
      end
      sclk_prev = sclk_o;
      sd_prev = sd_o;
      ready_prev = req_ready;
      done_prev = rd_done;
    end
  end

  // driver
  task automatic issue(int cmd, int addr, int data);
    logic [15:0] f;
    if (cmd < 2) begin
      f = {8'h00, 1'(cmd), 7'(addr)};
      exp_len_q.push_back(8);
    end else begin
      f = {1'b1, 7'(addr), 8'(data)};
      exp_len_q.push_back(16);
    end
    exp_cmd_q.push_back(cmd);
    exp_frame_q.push_back(f);
    case (cmd)
      0: exp_rd_q.push_back(ref_mem[addr]);
      1: begin exp_pulse_q.push_back(1); ref_mem[addr] = 8'h00; end
      2: begin exp_pulse_q.push_back(0); ref_mem[addr] = 8'(data); end
      default: begin
        exp_pulse_q.push_back(1);
        exp_pulse_q.push_back(0);
        ref_mem[addr] = 8'(data);
      end
    endcase
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_cmd = 2'(cmd);
    req_addr = 7'(addr);
    req_data = 8'(data);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!req_ready || exp_frame_q.size() != 0 || exp_rd_q.size() != 0 ||
           exp_pulse_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  bit timeout = 0;
  initial begin
    for (int i = 0; i < 128; i++) begin
      ref_mem[i] = 8'h00;
      mdl_mem[i] = 8'h00;
    end
    fork
      begin
        repeat (3) @(negedge clk);
        chk(ce_o == 1'b1, "R1", "reset ce", ce_o, 1);
        chk(sclk_o == 1'b0, "R1", "reset sclk", sclk_o, 0);
        chk(sd_oe_o == 1'b0, "R1", "reset oe", sd_oe_o, 0);
        chk(req_ready == 1'b1, "R1", "reset ready", req_ready, 1);
        chk(rd_done == 1'b0, "R1", "reset done", rd_done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ce_o && !sclk_o && !sd_oe_o && req_ready, "R1", "after reset", 0, 1);

        issue(0, 5, 0);
        issue(2, 5, 8'hA5);
        // R9: request while busy must be dropped
        repeat (10) @(negedge clk);
        chk(!req_ready, "R9", "ready low while busy", req_ready, 0);
        req_cmd = 2'b10; req_addr = 7'd9; req_data = 8'h77; req_valid = 1'b1;
        repeat (20) @(negedge clk);
        req_valid = 1'b0;
        issue(0, 5, 0);
        issue(2, 127, 8'h3C);
        issue(0, 127, 0);
        issue(3, 0, 8'h81);
        issue(0, 0, 0);
        issue(1, 5, 0);
        issue(0, 5, 0);
        issue(2, 42, 8'h5A);
        issue(3, 42, 8'hC3);
        issue(0, 42, 0);
        issue(0, 9, 0);
        wait_idle();
        chk(exp_frame_q.size() == 0, "R9", "no stray frame", exp_frame_q.size(), 0);
      end
      begin
        repeat (150000) @(posedge clk);
        timeout = 1;
      end
    join_any
    disable fork;
    if (timeout) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finish");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule